// File: doc/BRIEF.md
# Device Power State Controller

This block decides which of three power states the device is in and turns that state into the enables that the rest of the chip uses. The states are RESET, NORMAL and IDLE. An active-low reset pin holds the block in RESET. That reset is asserted asynchronously and released synchronously. After release, the block stays in RESET for a fixed number of clocks and then enters NORMAL (transition *bring-up*). While in NORMAL, the host sets a device-idle bit, and the block moves to IDLE (transition *park*). In IDLE, a wake-up event returns the block to NORMAL (transition *wake*). Asserting the reset pin sends the block back to RESET from any state (transition *abort*).

The block holds two host-written control bits: device-idle and power-management-idle. Host writes are accepted only while register access is enabled. In IDLE, clocks are gated, register access is frozen, the PHY is asked to suspend, and VBUS sensing moves from the regular comparators to the low-power comparator. ID detection stays on in IDLE. The SLEEP output tells a companion power chip that it may go to low power. SLEEP is raised only in IDLE, and only when both control bits are set.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs take these values within the same cycle: `pwr_state`=0 (RESET), `clk_en`=1, and `reg_acc_en`, `phy_suspend`, `vbus_lp_sel`, `vbus_cmp_en`, `id_det_en` and `sleep_o` all 0. Both control bits are cleared.
- R2: After `rst_n` rises, `pwr_state` changes to 1 (NORMAL) on exactly the (SYNC_STAGES+RST_HOLD)-th rising clock edge. With the defaults of 2 and 16, that is the 18th edge.
- R3: In NORMAL, the outputs are `clk_en`=1, `reg_acc_en`=1, `vbus_cmp_en`=1, `id_det_en`=1, `phy_suspend`=0, `vbus_lp_sel`=0 and `sleep_o`=0.
- R4: A write with `cfg_wr`=1 and `cfg_dev_idle`=1 in NORMAL is captured on the next rising edge. The block enters IDLE (`pwr_state`=2) on the edge after that.
- R5: In IDLE, the outputs are `clk_en`=0, `reg_acc_en`=0, `vbus_cmp_en`=0, `phy_suspend`=1, `vbus_lp_sel`=1 and `id_det_en`=1.
- R6: `sleep_o` is 1 only in IDLE, and only when both the device-idle bit and the power-management-idle bit are set. With device-idle set alone, the block is in IDLE and `sleep_o` is 0.
- R7: Setting only the power-management-idle bit in NORMAL leaves the block in NORMAL with `sleep_o`=0.
- R8: `wake_evt`=1 in IDLE moves the block to NORMAL on the next edge, and `sleep_o` falls in that same cycle. The wake also clears the device-idle bit, so the block stays in NORMAL afterwards.
- R9: Host writes made while in IDLE are ignored. A write that clears device-idle does not leave IDLE, and a write that sets power-management-idle does not raise `sleep_o`.
- R10: `wake_evt` in NORMAL or in RESET has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| cfg_wr | input | 1 | Host write strobe for the two control bits |
| cfg_dev_idle | input | 1 | Write data for the device-idle bit |
| cfg_pm_idle | input | 1 | Write data for the power-management-idle bit |
| wake_evt | input | 1 | Qualified wake-up event |
| pwr_state | output | 2 | Current state: 0 RESET, 1 NORMAL, 2 IDLE |
| clk_en | output | 1 | Enable for the gated clocks |
| reg_acc_en | output | 1 | Register read/write permitted |
| phy_suspend | output | 1 | PHY suspend request |
| vbus_lp_sel | output | 1 | Selects the low-power VBUS comparator |
| vbus_cmp_en | output | 1 | Enables the regular VBUS comparators |
| id_det_en | output | 1 | Enables ID pin detection |
| sleep_o | output | 1 | Sleep request to the companion power chip |

## Verification
The bench parks the block in IDLE with three combinations of the control bits: device-idle alone, both bits set, and the power-management bit alone in NORMAL. Together these show whether SLEEP really needs both bits as well as the IDLE state. Wake events are applied both inside and outside IDLE, which separates a correct wake path from one that reacts in every state or fails to clear the device-idle bit. Host writes attempted during IDLE show whether register access is actually frozen. An exact edge count after reset release catches an off-by-one in the hold counter, and dropping reset in the middle of a cycle from IDLE shows that reset entry does not wait for the clock.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [1:0] {
        PS_RESET  = 2'd0,
        PS_NORMAL = 2'd1,
        PS_IDLE   = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/psc_rst_sync.sv
module psc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_int_n
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/psc_ctl_bits.sv
module psc_ctl_bits (
    input  logic clk,
    input  logic rst_int_n,
    input  logic acc_en,
    input  logic wake_clr,
    input  logic wr,
    input  logic dev_idle_d,
    input  logic pm_idle_d,
    output logic dev_idle_q,
    output logic pm_idle_q
);
    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) begin
            dev_idle_q <= 1'b0;
            pm_idle_q  <= 1'b0;
        end else if (wake_clr) begin
            dev_idle_q <= 1'b0;
        end else if (wr && acc_en) begin
            dev_idle_q <= dev_idle_d;
            pm_idle_q  <= pm_idle_d;
        end
    end

    // R9
    frozen_bits_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (!acc_en && !wake_clr) |=> ($stable(dev_idle_q) && $stable(pm_idle_q)));

    // R8
    wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        wake_clr |=> !dev_idle_q);
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
    import psc_pkg::*;
#(
    parameter int RST_HOLD = 16
) (
    input  logic       clk,
    input  logic       rst_int_n,
    input  logic       dev_idle,
    input  logic       pm_idle,
    input  logic       wake_evt,
    output logic       wake_clr,
    output logic [1:0] state_o,
    output logic       clk_en,
    output logic       reg_acc_en,
    output logic       phy_suspend,
    output logic       vbus_lp_sel,
    output logic       vbus_cmp_en,
    output logic       id_det_en,
    output logic       sleep_o
);
    localparam int CNT_W = (RST_HOLD > 1) ? $clog2(RST_HOLD) : 1;
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD - 1);

    pwr_state_e state_q, state_d;
    logic [CNT_W-1:0] hold_cnt_q;
    logic hold_done;

    assign hold_done = (hold_cnt_q == HOLD_LAST);
    assign wake_clr  = (state_q == PS_IDLE) && wake_evt;

    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n)                          hold_cnt_q <= '0;
        else if (state_q == PS_RESET && !hold_done) hold_cnt_q <= hold_cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RESET:  if (hold_done) state_d = PS_NORMAL;
            PS_NORMAL: if (dev_idle)  state_d = PS_IDLE;
            PS_IDLE:   if (wake_evt)  state_d = PS_NORMAL;
            default:                  state_d = PS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) state_q <= PS_RESET;
        else            state_q <= state_d;
    end

    always_comb begin
        clk_en      = 1'b1;
        reg_acc_en  = 1'b0;
        phy_suspend = 1'b0;
        vbus_lp_sel = 1'b0;
        vbus_cmp_en = 1'b0;
        id_det_en   = 1'b0;
        sleep_o     = 1'b0;
        unique case (state_q)
            PS_NORMAL: begin
                reg_acc_en  = 1'b1;
                vbus_cmp_en = 1'b1;
                id_det_en   = 1'b1;
            end
            PS_IDLE: begin
                clk_en      = 1'b0;
                phy_suspend = 1'b1;
                vbus_lp_sel = 1'b1;
                id_det_en   = 1'b1;
                sleep_o     = dev_idle && pm_idle;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    // R2
    reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (state_q == PS_RESET) |=> (state_q == PS_RESET || state_q == PS_NORMAL));

    // R4
    park_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (state_q == PS_NORMAL && dev_idle) |=> (state_q == PS_IDLE));

    // R8
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (state_q == PS_IDLE && wake_evt) |=> (state_q == PS_NORMAL && !sleep_o));

    // R10
    stay_normal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (state_q == PS_NORMAL && !dev_idle) |=> (state_q == PS_NORMAL));

    // R6
    sleep_qual_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        sleep_o |-> (dev_idle && pm_idle && !reg_acc_en));
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int RST_HOLD    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_dev_idle,
    input  logic       cfg_pm_idle,
    input  logic       wake_evt,
    output logic [1:0] pwr_state,
    output logic       clk_en,
    output logic       reg_acc_en,
    output logic       phy_suspend,
    output logic       vbus_lp_sel,
    output logic       vbus_cmp_en,
    output logic       id_det_en,
    output logic       sleep_o
);
    logic rst_int_n;
    logic dev_idle_q, pm_idle_q, wake_clr;

    psc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_int_n (rst_int_n)
    );

    psc_ctl_bits u_bits (
        .clk        (clk),
        .rst_int_n  (rst_int_n),
        .acc_en     (reg_acc_en),
        .wake_clr   (wake_clr),
        .wr         (cfg_wr),
        .dev_idle_d (cfg_dev_idle),
        .pm_idle_d  (cfg_pm_idle),
        .dev_idle_q (dev_idle_q),
        .pm_idle_q  (pm_idle_q)
    );

    psc_fsm #(.RST_HOLD(RST_HOLD)) u_fsm (
        .clk         (clk),
        .rst_int_n   (rst_int_n),
        .dev_idle    (dev_idle_q),
        .pm_idle     (pm_idle_q),
        .wake_evt    (wake_evt),
        .wake_clr    (wake_clr),
        .state_o     (pwr_state),
        .clk_en      (clk_en),
        .reg_acc_en  (reg_acc_en),
        .phy_suspend (phy_suspend),
        .vbus_lp_sel (vbus_lp_sel),
        .vbus_cmp_en (vbus_cmp_en),
        .id_det_en   (id_det_en),
        .sleep_o     (sleep_o)
    );

    // R1
    reset_outputs_chk: assert property (@(posedge clk)
        !rst_n |-> (pwr_state == 2'd0 && !sleep_o && !reg_acc_en));
endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC_N = 2;
    localparam int HOLD_N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_dev_idle = 1'b0, cfg_pm_idle = 1'b0, wake_evt = 1'b0;
    logic [1:0] pwr_state;
    logic clk_en, reg_acc_en, phy_suspend, vbus_lp_sel, vbus_cmp_en, id_det_en, sleep_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_state_ctrl #(.SYNC_STAGES(SYNC_N), .RST_HOLD(HOLD_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dev_idle(cfg_dev_idle),
        .cfg_pm_idle(cfg_pm_idle), .wake_evt(wake_evt), .pwr_state(pwr_state),
        .clk_en(clk_en), .reg_acc_en(reg_acc_en), .phy_suspend(phy_suspend),
        .vbus_lp_sel(vbus_lp_sel), .vbus_cmp_en(vbus_cmp_en), .id_det_en(id_det_en),
        .sleep_o(sleep_o)
    );

    // {state, clk_en, reg_acc_en, phy_suspend, vbus_lp_sel, vbus_cmp_en, id_det_en, sleep_o}
    localparam logic [8:0] EXP_RESET  = {2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [8:0] EXP_NORMAL = {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [8:0] EXP_IDLE   = {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [8:0] EXP_SLEEP  = {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

    function automatic logic [8:0] observed();
        return {pwr_state, clk_en, reg_acc_en, phy_suspend, vbus_lp_sel,
                vbus_cmp_en, id_det_en, sleep_o};
    endfunction

    task automatic check(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = observed();
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic dev, input logic pm);
        cfg_wr = 1'b1; cfg_dev_idle = dev; cfg_pm_idle = pm;
        edges(1);
        cfg_wr = 1'b0; cfg_dev_idle = 1'b0; cfg_pm_idle = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1;
        edges(1);
        wake_evt = 1'b0;
    endtask

    task automatic t_reset_and_bringup();
        rst_n = 1'b0;
        edges(3);
        check("R1 reset values", EXP_RESET);
        wake_evt = 1'b1;                 // R10: wake in RESET has no effect
        rst_n = 1'b1;
        edges(SYNC_N + HOLD_N - 1);
        check("R2 still RESET one edge early", EXP_RESET);
        wake_evt = 1'b0;
        edges(1);
        check("R2 R3 NORMAL at exact edge", EXP_NORMAL);
    endtask

    task automatic t_park_no_sleep();
        host_write(1'b1, 1'b0);
        check("R4 not yet IDLE after capture edge", EXP_NORMAL);
        edges(1);
        check("R5 R6 IDLE with device-idle alone", EXP_IDLE);
    endtask

    task automatic t_ignored_writes();
        host_write(1'b0, 1'b1);
        check("R9 write in IDLE ignored", EXP_IDLE);
        edges(2);
        check("R9 still IDLE no sleep", EXP_IDLE);
    endtask

    task automatic t_wake_back();
        pulse_wake();
        check("R8 NORMAL after wake", EXP_NORMAL);
        edges(3);
        check("R8 device-idle cleared stays NORMAL", EXP_NORMAL);
    endtask

    task automatic t_pm_alone();
        host_write(1'b0, 1'b1);
        edges(2);
        check("R7 pm-idle alone stays NORMAL", EXP_NORMAL);
    endtask

    task automatic t_wake_in_normal();
        wake_evt = 1'b1;
        edges(3);
        wake_evt = 1'b0;
        check("R10 wake in NORMAL no effect", EXP_NORMAL);
    endtask

    task automatic t_sleep_and_wake();
        host_write(1'b1, 1'b1);
        edges(1);
        check("R6 sleep with both bits in IDLE", EXP_SLEEP);
        edges(4);
        check("R6 sleep held while IDLE", EXP_SLEEP);
        wake_evt = 1'b1;
        #1;
        check("R8 sleep still high before edge", EXP_SLEEP);
        edges(1);
        wake_evt = 1'b0;
        check("R8 sleep low same cycle as exit", EXP_NORMAL);
    endtask

    task automatic t_async_abort();
        host_write(1'b1, 1'b1);
        edges(1);
        check("R6 re-entered sleep", EXP_SLEEP);
        #2;
        rst_n = 1'b0;
        #1;
        check("R1 asynchronous entry to RESET", EXP_RESET);
        edges(2);
        rst_n = 1'b1;
        edges(SYNC_N + HOLD_N);
        check("R1 bits cleared after reset", EXP_NORMAL);
        edges(2);
        check("R1 no re-park after reset", EXP_NORMAL);
    endtask

    initial begin
        edges(1);
        t_reset_and_bringup();
        t_park_no_sleep();
        t_ignored_writes();
        t_wake_back();
        t_pm_alone();
        t_wake_in_normal();
        t_sleep_and_wake();
        t_async_abort();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule